// File: doc/BRIEF.md
# LED Fault Status Capture Holder

This block sits between the per-channel fault comparators of a constant-current LED driver and its serial readout path. Each channel supplies two raw comparator flags. The open flag is set when the output voltage is below the open threshold. The short flag is set when the output voltage is above the programmed short threshold. The block gates both flags with the channel's on/off state, so a channel that is switched off never reports a fault. It then captures one set of flags into a status holder that is one bit per channel wide.

A 2-bit code chooses which flag set is captured: open data or short data. Two timing sources can trigger a capture:
- the rising edge of the blanking input, in normal operation;
- a done strobe at the end of an invisible-detection window, when that mode is enabled.

The comparators need time before their flags can be trusted:
- The blanking input must have been low for a parameterised number of clock cycles.
- After a power-save period ends, a second parameterised wake delay must have elapsed.

A capture request that arrives before the flags are trustworthy leaves the holder untouched and sets a sticky invalid flag. A load strobe copies the holder into a shift register, which is then clocked out MSB-first on the serial output.

Top module: `led_fault_holder`

## Requirements
- R1: With `sel` = 2'b01 and `idm_en` low, a rising edge on `blank` while detection is ready loads the holder with `open_flag & chan_on`. The holder is visible on `hold_q` after that clock edge.
- R2: With `sel` = 2'b10, the same capture event loads the holder with `short_flag & chan_on` instead.
- R3: Every holder bit whose `chan_on` bit was 0 at the capture edge reads 0 after the capture, whatever its raw flag was.
- R4: With `sel` = 2'b00 or 2'b11, a capture event leaves both `hold_q` and `invalid_o` unchanged.
- R5: With `idm_en` high, the capture event is a one-cycle high on `idm_done`, and a rising edge on `blank` captures nothing.
- R6: Detection is ready only once `blank` has been sampled low on at least `SETTLE_CYC` consecutive clock edges before the capture event. A capture request made earlier leaves `hold_q` unchanged and sets `invalid_o`.
- R7: While `pwr_save` is high, and for the first `WAKE_CYC` clock edges after it is sampled low, detection is not ready. A capture request in that time sets `invalid_o` and leaves `hold_q` unchanged.
- R8: `invalid_o` stays set until a cycle with `load` high clears it. A successful capture does not clear it.
- R9: A cycle with `load` high copies `hold_q` into the shift register, and `sout` then shows bit NCH-1. Each cycle with `shift` high (and `load` low) moves the next lower bit onto `sout` and shifts in 0 from the bottom.
- R10: After reset, `hold_q` is 0, `sout` is 0 and `invalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| open_flag | input | NCH | Raw open-LED comparator flags |
| short_flag | input | NCH | Raw shorted-LED comparator flags |
| chan_on | input | NCH | Channel on/off state, 1 = on |
| blank | input | 1 | Blanking input; its rising edge is the normal capture event |
| sel | input | 2 | Capture source: 01 open, 10 short, 00/11 none |
| idm_en | input | 1 | Invisible-detection mode enable |
| idm_done | input | 1 | End-of-detection-window strobe |
| pwr_save | input | 1 | High while the front end is in power save |
| load | input | 1 | Copy the holder into the shift register; clear the invalid flag |
| shift | input | 1 | Shift the register one place toward the MSB |
| sout | output | 1 | Serial output, MSB of the shift register |
| hold_q | output | NCH | Status holder contents |
| invalid_o | output | 1 | Sticky flag for a premature capture request |

## Verification
The bench builds the block with NCH = 8, SETTLE_CYC = 6 and WAKE_CYC = 4. With these values both readiness windows are only a few cycles long. The bench can therefore reach both sides of each boundary directly:
- a blanking low time of 5 versus 6 cycles;
- a wake time of 3 versus 4 cycles.

The narrow channel count lets one full serial readout per capture pattern finish quickly. The bench also uses patterns in which some channels are switched off while their raw flags are set.

// File: rtl/lfh_pkg.sv
package lfh_pkg;

  typedef enum logic [1:0] {
    SRC_NONE_LO = 2'b00,
    SRC_OPEN    = 2'b01,
    SRC_SHORT   = 2'b10,
    SRC_NONE_HI = 2'b11
  } src_sel_e;

  function automatic logic sel_is_active(input logic [1:0] s);
    return (s == SRC_OPEN) || (s == SRC_SHORT);
  endfunction

  function automatic logic ready_after(input int unsigned count, input int unsigned need);
    return count >= need;
  endfunction

endpackage

// File: rtl/lfh_sat_counter.sv
module lfh_sat_counter #(
  parameter int unsigned LIMIT    = 100,
  parameter bit          RST_FULL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic done
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_FULL ? LIM : '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (cnt_q < LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = lfh_pkg::ready_after(int'(cnt_q), LIMIT);
endmodule

// File: rtl/lfh_capture.sv
module lfh_capture #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] open_flag,
  input  logic [NCH-1:0] short_flag,
  input  logic [NCH-1:0] chan_on,
  input  logic [1:0]     sel,
  input  logic           cap_evt,
  input  logic           det_ready,
  input  logic           load,
  output logic [NCH-1:0] hold_q,
  output logic           invalid_o,
  output logic           cap_req,
  output logic           cap_fire
);
  import lfh_pkg::*;

  function automatic logic [NCH-1:0] gated_pick(
    input logic [1:0]     s,
    input logic [NCH-1:0] op,
    input logic [NCH-1:0] sh,
    input logic [NCH-1:0] on
  );
    logic [NCH-1:0] raw;
    raw = (s == SRC_SHORT) ? sh : op;
    return raw & on;
  endfunction

  logic cap_early;

  assign cap_req   = cap_evt && sel_is_active(sel);
  assign cap_fire  = cap_req && det_ready;
  assign cap_early = cap_req && !det_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (cap_fire) begin
      hold_q <= gated_pick(sel, open_flag, short_flag, chan_on);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      invalid_o <= 1'b0;
    end else if (cap_early) begin
      invalid_o <= 1'b1;
    end else if (load) begin
      invalid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lfh_shift.sv
module lfh_shift #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           shift,
  input  logic [NCH-1:0] par_in,
  output logic           sout
);
  logic [NCH-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= par_in;
    end else if (shift) begin
      sr_q <= {sr_q[NCH-2:0], 1'b0};
    end
  end

  assign sout = sr_q[NCH-1];
endmodule

// File: rtl/led_fault_holder.sv
module led_fault_holder #(
  parameter int unsigned NCH        = 16,
  parameter int unsigned SETTLE_CYC = 100,
  parameter int unsigned WAKE_CYC   = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] open_flag,
  input  logic [NCH-1:0] short_flag,
  input  logic [NCH-1:0] chan_on,
  input  logic           blank,
  input  logic [1:0]     sel,
  input  logic           idm_en,
  input  logic           idm_done,
  input  logic           pwr_save,
  input  logic           load,
  input  logic           shift,
  output logic           sout,
  output logic [NCH-1:0] hold_q,
  output logic           invalid_o
);
  logic blank_q;
  logic blank_rise;
  logic cap_evt;
  logic settle_ok;
  logic wake_ok;
  logic det_ready;
  logic cap_req;
  logic cap_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blank_q <= 1'b1;
    else        blank_q <= blank;
  end

  assign blank_rise = blank && !blank_q;
  assign cap_evt    = idm_en ? idm_done : blank_rise;

  lfh_sat_counter #(.LIMIT(SETTLE_CYC), .RST_FULL(1'b0)) i_settle (
    .clk(clk), .rst_n(rst_n), .clr(blank), .done(settle_ok)
  );

  lfh_sat_counter #(.LIMIT(WAKE_CYC), .RST_FULL(1'b1)) i_wake (
    .clk(clk), .rst_n(rst_n), .clr(pwr_save), .done(wake_ok)
  );

  assign det_ready = settle_ok && wake_ok && !pwr_save;

  lfh_capture #(.NCH(NCH)) i_capture (
    .clk(clk), .rst_n(rst_n),
    .open_flag(open_flag), .short_flag(short_flag), .chan_on(chan_on),
    .sel(sel), .cap_evt(cap_evt), .det_ready(det_ready), .load(load),
    .hold_q(hold_q), .invalid_o(invalid_o),
    .cap_req(cap_req), .cap_fire(cap_fire)
  );

  lfh_shift #(.NCH(NCH)) i_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .par_in(hold_q), .sout(sout)
  );
endmodule

// File: rtl/led_fault_holder_chk.sv
module led_fault_holder_chk #(
  parameter int unsigned NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_on,
  input logic           load,
  input logic           shift,
  input logic [NCH-1:0] hold_q,
  input logic           invalid_o,
  input logic           sout,
  input logic           cap_req,
  input logic           cap_fire,
  input logic           det_ready
);
  AST_OFF_CHAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> ((hold_q & ~$past(chan_on)) == '0)); // R3

  AST_HOLD_ONLY_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> $stable(hold_q)); // R6

  AST_EARLY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_req && !det_ready) |=> invalid_o); // R7

  AST_INVALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (invalid_o && !load) |=> invalid_o); // R8

  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sout == $past(hold_q[NCH-1]))); // R9

  AST_IDLE_SOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(sout)); // R9
endmodule

bind led_fault_holder led_fault_holder_chk #(.NCH(NCH)) i_chk (.*);

// File: tb/test_led_fault_holder.sv
module test_led_fault_holder;
  localparam int N  = 8;
  localparam int ST = 6;
  localparam int WK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] open_flag = '0, short_flag = '0, chan_on = '0;
  logic blank = 1'b1, idm_en = 1'b0, idm_done = 1'b0, pwr_save = 1'b0;
  logic load = 1'b0, shift = 1'b0;
  logic [1:0] sel = 2'b00;
  logic sout, invalid_o;
  logic [N-1:0] hold_q;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  led_fault_holder #(.NCH(N), .SETTLE_CYC(ST), .WAKE_CYC(WK)) i_led_fault_holder (
    .clk(clk), .rst_n(rst_n), .open_flag(open_flag), .short_flag(short_flag),
    .chan_on(chan_on), .blank(blank), .sel(sel), .idm_en(idm_en),
    .idm_done(idm_done), .pwr_save(pwr_save), .load(load), .shift(shift),
    .sout(sout), .hold_q(hold_q), .invalid_o(invalid_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] expect_mask(input logic [N-1:0] f, input logic [N-1:0] on);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = on[i] ? f[i] : 1'b0;
    return r;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // blank low for k sampled edges, then rising edge; result visible at the following negedge
  task automatic blank_pulse(input int k);
    blank = 1'b0; cyc(k);
    blank = 1'b1; cyc(1);
  endtask

  task automatic read_check(input string req, input logic [N-1:0] exp);
    load = 1'b1; cyc(1); load = 1'b0;
    for (int b = N - 1; b >= 0; b--) begin
      chk(req, sout, exp[b]);
      shift = 1'b1; cyc(1); shift = 1'b0;
    end
    chk(req, sout, 1'b0);
  endtask

  task automatic t_reset;
    chk("R10 hold", hold_q, 0);
    chk("R10 sout", sout, 0);
    chk("R10 invalid", invalid_o, 0);
  endtask

  task automatic t_open;
    open_flag = 8'hA5; short_flag = 8'h3C; chan_on = 8'hFF; sel = 2'b01;
    blank_pulse(ST);
    chk("R1 open", hold_q, expect_mask(8'hA5, 8'hFF));
    chk("R1 valid", invalid_o, 0);
    read_check("R9 serial open", 8'hA5);
  endtask

  task automatic t_short_masked;
    open_flag = 8'hFF; short_flag = 8'hF3; chan_on = 8'h5A; sel = 2'b10;
    blank_pulse(ST + 2);
    chk("R2 short", hold_q, expect_mask(8'hF3, 8'h5A));
    chk("R3 off zero", hold_q & ~8'h5A, 0);
    sel = 2'b01; chan_on = 8'h0F;
    blank_pulse(ST);
    chk("R3 open masked", hold_q, 8'h0F);
    read_check("R9 serial masked", 8'h0F);
  endtask

  task automatic t_nosel;
    logic [N-1:0] prev;
    prev = hold_q;
    open_flag = 8'h11; short_flag = 8'h22; chan_on = 8'hFF;
    sel = 2'b00; blank_pulse(ST);
    chk("R4 sel00 hold", hold_q, prev);
    sel = 2'b11; blank_pulse(1);
    chk("R4 sel11 hold", hold_q, prev);
    chk("R4 no invalid", invalid_o, 0);
  endtask

  task automatic t_settle;
    open_flag = 8'h81; chan_on = 8'hFF; sel = 2'b01;
    blank_pulse(ST);
    chk("R6 at boundary", hold_q, 8'h81);
    open_flag = 8'h7E;
    blank_pulse(ST - 1);
    chk("R6 early hold", hold_q, 8'h81);
    chk("R6 early invalid", invalid_o, 1);
    blank_pulse(ST);
    chk("R8 sticky", invalid_o, 1);
    chk("R6 later capture", hold_q, 8'h7E);
    read_check("R8 load clears", 8'h7E);
    chk("R8 cleared", invalid_o, 0);
  endtask

  task automatic t_wake;
    open_flag = 8'h3C; chan_on = 8'hFF; sel = 2'b01;
    blank = 1'b0; cyc(ST + 2);
    pwr_save = 1'b1; cyc(3);
    blank = 1'b1; cyc(1);
    chk("R7 in powersave", invalid_o, 1);
    chk("R7 hold kept", hold_q, 8'h7E);
    load = 1'b1; cyc(1); load = 1'b0;
    blank = 1'b0; cyc(ST + 1);
    pwr_save = 1'b1; cyc(2); pwr_save = 1'b0; cyc(WK - 1);
    blank = 1'b1; cyc(1);
    chk("R7 wake early", invalid_o, 1);
    chk("R7 wake hold", hold_q, 8'h7E);
    load = 1'b1; cyc(1); load = 1'b0;
    blank = 1'b0; cyc(ST + 1);
    pwr_save = 1'b1; cyc(2); pwr_save = 1'b0; cyc(WK);
    blank = 1'b1; cyc(1);
    chk("R7 wake done", invalid_o, 0);
    chk("R7 wake capture", hold_q, 8'h3C);
  endtask

  task automatic t_idm;
    idm_en = 1'b1; sel = 2'b10; short_flag = 8'hC3; chan_on = 8'hF0;
    blank_pulse(ST + 1);
    chk("R5 blank ignored", hold_q, 8'h3C);
    blank = 1'b0; cyc(ST);
    idm_done = 1'b1; cyc(1); idm_done = 1'b0;
    chk("R5 idm capture", hold_q, expect_mask(8'hC3, 8'hF0));
    blank = 1'b1; cyc(1);
    idm_en = 1'b0;
    read_check("R9 serial idm", 8'hC0);
  endtask

  initial begin
    cyc(2); rst_n = 1'b1; cyc(1);
    t_reset();
    t_open();
    t_short_masked();
    t_nosel();
    t_settle();
    t_wake();
    t_idm();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule